// File: doc/BRIEF.md
# Perspective-Adaptive Row Step Filter

This block turns a grayscale video frame into a binary lane-marking mask, one image row at a time. Each incoming row is captured whole into on-chip storage. The block then sweeps that row and, for every column, weighs the centre pixel against two side pixels. The side pixels sit a row-specific lateral distance (tau) to the left and to the right. Near the bottom of the image tau is large, and it shrinks toward the horizon, so one filter can follow the perspective of the road.

The response rewards a pixel that is brighter than both of its sides. A penalty equal to the absolute difference between the two sides is then subtracted, so a plain edge is rejected and only a stripe whose two sides match passes. The signed response is compared with a programmable threshold, and each output pixel is either all ones or all zeros. Two columns are evaluated in every cycle, and both results go out together in one output beat.

A processor loads a table with one tau per row and sets the threshold through simple write ports. Pixels arrive on an AXI4-Stream input, and the mask leaves on an AXI4-Stream output whose beats are two pixels wide.

Top module: `row_step_filter`

## Requirements
- R1: After reset the input side is ready (s_tready = 1) and no output beat is offered (m_tvalid = 0).
- R2: A row is exactly COLS input pixels, taken in column order, and s_tlast marks the last of them. After that last pixel, s_tready stays low until the final output beat of the row has been accepted. It is high again in the cycle that follows.
- R3: For a column c with side pixels a = x(c−tau) and b = x(c+tau), the response is 2·x(c) − a − b − |a − b|, evaluated signed. The output byte is 0xFF when the response is strictly greater than the threshold.
- R4: When the response is equal to the threshold or below it, negative values included, the output byte is 0x00.
- R5: Columns where c − tau < 0 or c + tau > COLS−1 always output 0x00.
- R6: The tau used for row n of a frame is entry n of the tau table, which is written through cfg_tau_we / cfg_row / cfg_tau. The threshold is the last value written through cfg_thr_we / cfg_thr.
- R7: Each row is emitted as COLS/2 output beats in column order. On m_tdata, bits [7:0] carry the even column and bits [15:8] carry the next odd column.
- R8: m_tlast is high only on the last beat of each row.
- R9: m_tuser is high only on the first beat of row 0. The row index returns to 0 after ROWS rows.
- R10: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata, m_tlast and m_tuser hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_tau_we | input | 1 | Write strobe for the tau table |
| cfg_row | input | ROW_W | Row index of the tau table entry being written |
| cfg_tau | input | TAU_W | Tau value to store for that row |
| cfg_thr_we | input | 1 | Write strobe for the threshold |
| cfg_thr | input | PIX_W+1 | Threshold value (unsigned) |
| s_tvalid | input | 1 | Input pixel valid |
| s_tready | output | 1 | Input pixel accepted |
| s_tdata | input | PIX_W | Input pixel |
| s_tlast | input | 1 | Marks the last pixel of a row |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the beat |
| m_tdata | output | 2*PIX_W | Two mask pixels, even column in the low byte |
| m_tlast | output | 1 | Last beat of a row |
| m_tuser | output | 1 | First beat of a frame |

## Verification
A wrong tau latch or a wrong read address corrupts mask bytes in the very row it affects. The error is clearest at the columns next to the borders and on the stripe patterns, so the byte-by-byte comparison catches it within one row. A write or column counter that is off by one shifts the whole mask, or moves m_tlast to a different beat, and this too is visible within a single row. A row counter that fails to wrap shows up only after ROWS rows, as a missing or extra m_tuser, so the sweep covers several frames. A broken backpressure path shows as a beat that changes under a low m_tready, which is visible in the very next cycle.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_FILT  = 2'd1,
    ST_DRAIN = 2'd2
  } rsf_state_e;

  localparam int LANES = 2;
  localparam int TAPS  = 3;
endpackage

// File: rtl/rsf_rowbuf.sv
module rsf_rowbuf #(
  parameter int DEPTH = 320,
  parameter int W     = 8,
  parameter int NRD   = 6,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr [NRD],
  output logic [W-1:0]  rdata [NRD]
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar i = 0; i < NRD; i++) begin : g_rd
    always_comb rdata[i] = mem[raddr[i]];
  end
endmodule

// File: rtl/rsf_tau_table.sv
module rsf_tau_table #(
  parameter int ROWS  = 240,
  parameter int TAU_W = 5,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             we,
  input  logic [ROW_W-1:0] waddr,
  input  logic [TAU_W-1:0] wdata,
  input  logic [ROW_W-1:0] raddr,
  output logic [TAU_W-1:0] rdata
);
  logic [TAU_W-1:0] tab [ROWS];

  always_ff @(posedge clk) begin
    if (we) tab[waddr] <= wdata;
  end

  always_comb rdata = tab[raddr];

  // R6
  tau_addr_chk: assert property (@(posedge clk) disable iff (!rst_i)
    we |-> (int'(waddr) < ROWS));
endmodule

// File: rtl/rsf_lane.sv
module rsf_lane #(
  parameter int PIX_W = 8,
  localparam int THR_W = PIX_W + 1,
  localparam int RW    = PIX_W + 3
) (
  input  logic [PIX_W-1:0] ctr,
  input  logic [PIX_W-1:0] lft,
  input  logic [PIX_W-1:0] rgt,
  input  logic             in_rng,
  input  logic [THR_W-1:0] thr,
  output logic [PIX_W-1:0] mask
);
  logic signed [RW-1:0] c_s, l_s, r_s, mac, diff, adj, resp, thr_s;
  logic hit;

  always_comb begin
    c_s   = signed'({{(RW-PIX_W){1'b0}}, ctr});
    l_s   = signed'({{(RW-PIX_W){1'b0}}, lft});
    r_s   = signed'({{(RW-PIX_W){1'b0}}, rgt});
    thr_s = signed'({{(RW-THR_W){1'b0}}, thr});
    mac   = (c_s <<< 1) - l_s - r_s;
    diff  = l_s - r_s;
    adj   = diff[RW-1] ? diff : -diff;
    resp  = mac + adj;
    hit   = in_rng && (resp > thr_s);
    mask  = hit ? {PIX_W{1'b1}} : {PIX_W{1'b0}};
  end
endmodule

// File: rtl/row_step_filter.sv
module row_step_filter #(
  parameter int COLS  = 320,
  parameter int ROWS  = 240,
  parameter int PIX_W = 8,
  parameter int TAU_W = 5,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS),
  localparam int THR_W = PIX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_tau_we,
  input  logic [ROW_W-1:0]   cfg_row,
  input  logic [TAU_W-1:0]   cfg_tau,
  input  logic               cfg_thr_we,
  input  logic [THR_W-1:0]   cfg_thr,
  input  logic               s_tvalid,
  output logic               s_tready,
  input  logic [PIX_W-1:0]   s_tdata,
  input  logic               s_tlast,
  output logic               m_tvalid,
  input  logic               m_tready,
  output logic [2*PIX_W-1:0] m_tdata,
  output logic               m_tlast,
  output logic               m_tuser
);
  import rsf_pkg::*;

  localparam int CW1  = COL_W + 1;
  localparam int NRD  = LANES * TAPS;
  localparam int OUTW = LANES * PIX_W;

  // reset: asynchronous assert, synchronous release
  logic rs1_q, rs2_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  rsf_state_e st_q, st_d;
  logic [COL_W-1:0] wcol_q, wcol_d, pcol_q, pcol_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [TAU_W-1:0] tau_q, tau_d, tau_rd;
  logic [THR_W-1:0] thr_q, thr_d;
  logic             ov_q, ov_d, ol_q, ol_d, ou_q, ou_d;
  logic [OUTW-1:0]  od_q, od_d;
  logic             adv, in_hs;

  logic [COL_W-1:0] raddr [NRD];
  logic [PIX_W-1:0] rdata [NRD];
  logic [PIX_W-1:0] lane_mask [LANES];
  logic [OUTW-1:0]  pair;

  assign in_hs = s_tvalid && s_tready;

  rsf_rowbuf #(.DEPTH(COLS), .W(PIX_W), .NRD(NRD)) u_row (
    .clk   (clk),
    .we    (in_hs),
    .waddr (wcol_q),
    .wdata (s_tdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  rsf_tau_table #(.ROWS(ROWS), .TAU_W(TAU_W)) u_tau (
    .clk   (clk),
    .rst_i (rst_i),
    .we    (cfg_tau_we),
    .waddr (cfg_row),
    .wdata (cfg_tau),
    .raddr (row_q),
    .rdata (tau_rd)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [CW1-1:0] col_e, tau_e, lo_e, hi_e;
    logic           lo_ok, hi_ok;

    always_comb begin
      col_e = {1'b0, pcol_q} + CW1'(k);
      tau_e = CW1'(tau_q);
      lo_e  = col_e - tau_e;
      hi_e  = col_e + tau_e;
      lo_ok = col_e >= tau_e;
      hi_ok = hi_e <= CW1'(COLS - 1);
      raddr[TAPS*k]     = col_e[COL_W-1:0];
      raddr[TAPS*k + 1] = lo_ok ? lo_e[COL_W-1:0] : '0;
      raddr[TAPS*k + 2] = hi_ok ? hi_e[COL_W-1:0] : '0;
    end

    rsf_lane #(.PIX_W(PIX_W)) u_lane (
      .ctr    (rdata[TAPS*k]),
      .lft    (rdata[TAPS*k + 1]),
      .rgt    (rdata[TAPS*k + 2]),
      .in_rng (lo_ok && hi_ok),
      .thr    (thr_q),
      .mask   (lane_mask[k])
    );

    assign pair[k*PIX_W +: PIX_W] = lane_mask[k];
  end

  // next state
  always_comb begin
    st_d   = st_q;
    wcol_d = wcol_q;
    pcol_d = pcol_q;
    row_d  = row_q;
    tau_d  = tau_q;
    thr_d  = cfg_thr_we ? cfg_thr : thr_q;
    ov_d   = ov_q;
    od_d   = od_q;
    ol_d   = ol_q;
    ou_d   = ou_q;
    adv    = !ov_q || m_tready;
    unique case (st_q)
      ST_LOAD: begin
        if (in_hs) begin
          if (wcol_q == COL_W'(COLS - 1)) begin
            wcol_d = '0;
            pcol_d = '0;
            tau_d  = tau_rd;
            st_d   = ST_FILT;
          end else begin
            wcol_d = wcol_q + 1'b1;
          end
        end
      end
      ST_FILT: begin
        if (adv) begin
          ov_d = 1'b1;
          od_d = pair;
          ol_d = (pcol_q == COL_W'(COLS - LANES));
          ou_d = (row_q == '0) && (pcol_q == '0);
          if (pcol_q == COL_W'(COLS - LANES)) st_d = ST_DRAIN;
          else pcol_d = pcol_q + COL_W'(LANES);
        end
      end
      ST_DRAIN: begin
        if (m_tready) begin
          ov_d  = 1'b0;
          ol_d  = 1'b0;
          ou_d  = 1'b0;
          st_d  = ST_LOAD;
          row_d = (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
        end
      end
      default: st_d = ST_LOAD;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= ST_LOAD;
      wcol_q <= '0;
      pcol_q <= '0;
      row_q  <= '0;
      tau_q  <= '0;
      thr_q  <= '0;
      ov_q   <= 1'b0;
      od_q   <= '0;
      ol_q   <= 1'b0;
      ou_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      wcol_q <= wcol_d;
      pcol_q <= pcol_d;
      row_q  <= row_d;
      tau_q  <= tau_d;
      thr_q  <= thr_d;
      ov_q   <= ov_d;
      od_q   <= od_d;
      ol_q   <= ol_d;
      ou_q   <= ou_d;
    end
  end

  assign s_tready = (st_q == ST_LOAD);
  assign m_tvalid = ov_q;
  assign m_tdata  = od_q;
  assign m_tlast  = ol_q;
  assign m_tuser  = ou_q;

  // R2
  busy_chk: assert property (@(posedge clk) disable iff (!rst_i)
    m_tvalid |-> !s_tready);

  // R2
  tlast_align_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (s_tvalid && s_tready && s_tlast) |=> !s_tready);

  // R8
  row_end_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (m_tvalid && m_tready && m_tlast) |=> (s_tready && !m_tvalid));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) &&
                                 $stable(m_tlast) && $stable(m_tuser)));

  // R3
  binary_chk: assert property (@(posedge clk) disable iff (!rst_i)
    m_tvalid |-> (($countones(m_tdata[PIX_W-1:0]) == 0 ||
                   $countones(m_tdata[PIX_W-1:0]) == PIX_W) &&
                  ($countones(m_tdata[OUTW-1:PIX_W]) == 0 ||
                   $countones(m_tdata[OUTW-1:PIX_W]) == PIX_W)));

  // R9
  tuser_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (m_tvalid && m_tuser) |-> !m_tlast);
endmodule

// File: tb/sim_row_step_filter.sv
module sim_row_step_filter;
  localparam int COLS   = 16;
  localparam int ROWS   = 3;
  localparam int PIX_W  = 8;
  localparam int TAU_W  = 3;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int THR_W  = PIX_W + 1;
  localparam int FRAMES = 5;

  logic clk, rst_n;
  logic cfg_tau_we, cfg_thr_we;
  logic [ROW_W-1:0] cfg_row;
  logic [TAU_W-1:0] cfg_tau;
  logic [THR_W-1:0] cfg_thr;
  logic s_tvalid, s_tready, s_tlast;
  logic [PIX_W-1:0] s_tdata;
  logic m_tvalid, m_tready, m_tlast, m_tuser;
  logic [2*PIX_W-1:0] m_tdata;

  int n_chk, n_fail, cyc;
  bit done;
  int rowpix [COLS];

  row_step_filter #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W), .TAU_W(TAU_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_tau_we(cfg_tau_we), .cfg_row(cfg_row), .cfg_tau(cfg_tau),
    .cfg_thr_we(cfg_thr_we), .cfg_thr(cfg_thr),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tlast(m_tlast), .m_tuser(m_tuser)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pix(int f, int r, int c);
    case (f % 5)
      0: return (c % 4 == 1) ? 200 : 30;
      1: return (f * 37 + r * 101 + c * c * 13 + c * 7) % 256;
      2: return 100;
      3: return (c * 16 + r * 5) % 256;
      default: return ((c * 53 + r * 29 + 11) * 7) % 256;
    endcase
  endfunction

  function automatic int thr_of(int f);
    case (f % 5)
      0: return 50;
      1: return 0;
      2: return 0;
      3: return 20;
      default: return 100;
    endcase
  endfunction

  function automatic int tau_of(int f, int r);
    return ((f * 3 + r) % 7) + 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic send_row(int f, int r);
    for (int c = 0; c < COLS; c++) begin
      rowpix[c] = pix(f, r, c);
      if (f % 2 == 1 && c % 3 == 1) begin
        @(negedge clk);
        s_tvalid = 1'b0;
      end
      @(negedge clk);
      s_tvalid = 1'b1;
      s_tdata  = PIX_W'(rowpix[c]);
      s_tlast  = (c == COLS - 1);
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic get_row(int f, int r);
    int beats = 0;
    bit got_last = 0;
    bit pend = 0;
    logic [2*PIX_W-1:0] hd;
    logic hl, hu;
    int tau = tau_of(f, r);
    int thr = thr_of(f);
    while (!got_last && beats <= COLS / 2) begin
      @(negedge clk);
      if (pend) begin
        check(m_tvalid && m_tdata == hd && m_tlast == hl && m_tuser == hu,
              "R10", int'(m_tdata), int'(hd));
      end
      m_tready = ((cyc * 7 + f + r) % 3) != 0;
      pend = m_tvalid && !m_tready;
      hd = m_tdata; hl = m_tlast; hu = m_tuser;
      if (m_tvalid && m_tready) begin
        if (beats == 0) check(!s_tready, "R2", int'(s_tready), 0);
        for (int k = 0; k < 2; k++) begin
          int c = 2 * beats + k;
          int e = 0;
          int got = int'(m_tdata[k*PIX_W +: PIX_W]);
          if (c - tau < 0 || c + tau > COLS - 1) begin
            check(got == 0, "R5", got, 0);
          end else begin
            int a = rowpix[c - tau];
            int b = rowpix[c + tau];
            int d = (a > b) ? a - b : b - a;
            int resp = 2 * rowpix[c] - a - b - d;
            e = (resp > thr) ? 255 : 0;
            if (e == 255) check(got == e, "R3 R6 R7", got, e);
            else check(got == e, "R4 R6 R7", got, e);
          end
        end
        check(m_tlast == (beats == COLS / 2 - 1), "R8", int'(m_tlast),
              int'(beats == COLS / 2 - 1));
        check(m_tuser == (r == 0 && beats == 0), "R9", int'(m_tuser),
              int'(r == 0 && beats == 0));
        beats++;
        if (m_tlast) got_last = 1;
      end
    end
    check(beats == COLS / 2, "R7", beats, COLS / 2);
    @(negedge clk);
    m_tready = 1'b0;
    check(s_tready && !m_tvalid, "R2", int'(s_tready), 1);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; done = 0;
    rst_n = 1'b0;
    cfg_tau_we = 0; cfg_thr_we = 0; cfg_row = '0; cfg_tau = '0; cfg_thr = '0;
    s_tvalid = 0; s_tdata = '0; s_tlast = 0; m_tready = 0;
    repeat (3) @(negedge clk);
    check(s_tready && !m_tvalid, "R1", int'({s_tready, m_tvalid}), 2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(s_tready && !m_tvalid, "R1", int'({s_tready, m_tvalid}), 2);
    for (int f = 0; f < FRAMES; f++) begin
      for (int r = 0; r < ROWS; r++) begin
        @(negedge clk);
        cfg_tau_we = 1; cfg_row = ROW_W'(r); cfg_tau = TAU_W'(tau_of(f, r));
      end
      @(negedge clk);
      cfg_tau_we = 0;
      cfg_thr_we = 1; cfg_thr = THR_W'(thr_of(f));
      @(negedge clk);
      cfg_thr_we = 0;
      for (int r = 0; r < ROWS; r++) begin
        send_row(f, r);
        get_row(f, r);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule